// File: doc/BRIEF.md
# Masked Dual-Rail Majority AND Datapath

This block computes a bank of parallel two-input AND functions in masked dual-rail precharge form. Each operand bit is combined with a random mask bit by XOR and carried on a true rail and a complement rail. The mask bit travels on its own rail pair. In each lane, one three-input majority gate takes the two true data rails and the true mask rail. A second majority gate takes the two complement data rails and the complement mask rail. The true output rail then carries (a AND b) XOR m, and the complement output rail carries its inverse.

A phase input selects between precharge and evaluation. During precharge every rail pair, the mask pair included, is held at (0,0). When evaluation starts, the operands are captured into input flops. At the same moment a fresh mask word is drawn from a degree-89 maximal-length shift-register sequence. Both the operands and the mask then stay fixed until the next evaluation starts. The majority outputs are registered in output flops. An unmasked copy of the result is registered alongside them, so the rest of the chip can see the plain AND value.

Top module: `masked_rail_and`

## Requirements
- R1: While reset is held, `q_true`, `q_comp` and `plain_q` are all zero.
- R2: After a clock edge at which the registered phase is precharge, `q_true` and `q_comp` are both all-zero one cycle later. Every internal rail pair, the mask pair included, is (0,0) throughout precharge.
- R3: After an evaluation start, the following holds one edge later and stays so while evaluation continues. For each lane i, `q_true[i]` = (opa[i] AND opb[i]) XOR m[i], and `q_comp[i]` is the inverse of `q_true[i]`.
- R4: `plain_q` equals opa AND opb of the current operation from one edge after the evaluation start. It holds that value unchanged through the following precharge.
- R5: An evaluation start is `evaluate`=1 sampled while the registered phase is precharge. Only at an evaluation start are `opa`, `opb` and the mask captured. Changes on `opa` and `opb` at any other time have no effect on the outputs.
- R6: The mask source is an 89-bit shift register, reset to the parameter SEED. On each evaluation start it shifts toward the high bit and inserts bit88 XOR bit37 at bit 0. Lane i uses bit i of the shifted value as m[i].
- R7: No rail pair, whether at the ports or inside a lane, ever shows (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evaluate | input | 1 | 1 = evaluation phase, 0 = precharge phase |
| opa | input | LANES | Plain first operand |
| opb | input | LANES | Plain second operand |
| q_true | output | LANES | Registered true rail of the masked result |
| q_comp | output | LANES | Registered complement rail of the masked result |
| plain_q | output | LANES | Registered unmasked AND result |

## Verification
The assertions assume several things about the inputs. Reset is asserted before the first clock edge. Every evaluation is preceded by at least one precharge cycle, because the block only starts an operation from precharge. They also assume that `LANES` does not exceed the shift-register length. The bench changes `evaluate`, `opa` and `opb` only on falling edges. It always returns to precharge between operations. It deliberately rewrites the operands in the cycles after capture, so that R5 can be observed at the ports while the assumptions still hold.

// File: rtl/mrail_pkg.sv
package mrail_pkg;

    typedef enum logic {
        PH_PRE  = 1'b0,
        PH_EVAL = 1'b1
    } phase_e;

    function automatic logic maj3(input logic x, input logic y, input logic r);
        return (x & y) | (x & r) | (y & r);
    endfunction

endpackage

// File: rtl/mask_sr.sv
module mask_sr #(
    parameter int             LEN  = 89,
    parameter int             TAP  = 38,
    parameter logic [LEN-1:0] SEED = 89'h1_2345_6789_ABCD_EF01_2345
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    output logic [LEN-1:0] state_q,
    output logic [LEN-1:0] state_nx
);
    localparam int HI_IDX  = LEN - 1;
    localparam int TAP_IDX = TAP - 1;

    logic [LEN-1:0] state_d;

    always_comb begin
        state_nx = {state_q[LEN-2:0], state_q[HI_IDX] ^ state_q[TAP_IDX]};
        state_d  = advance ? state_nx : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rail_and_lane.sv
module rail_and_lane
    import mrail_pkg::*;
(
    input  logic eval_on,
    input  logic a,
    input  logic b,
    input  logic m,
    output logic a_t,
    output logic a_f,
    output logic b_t,
    output logic b_f,
    output logic m_t,
    output logic m_f,
    output logic q_t,
    output logic q_f
);
    always_comb begin
        a_t = eval_on & (a ^ m);
        a_f = eval_on & ~(a ^ m);
        b_t = eval_on & (b ^ m);
        b_f = eval_on & ~(b ^ m);
        m_t = eval_on & m;
        m_f = eval_on & ~m;
        q_t = maj3(a_t, b_t, m_t);
        q_f = maj3(a_f, b_f, m_f);
    end
endmodule

// File: rtl/masked_rail_and.sv
module masked_rail_and
    import mrail_pkg::*;
#(
    parameter int                LANES  = 32,
    parameter int                SR_LEN = 89,
    parameter int                SR_TAP = 38,
    parameter logic [SR_LEN-1:0] SEED   = 89'h1_2345_6789_ABCD_EF01_2345
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evaluate,
    input  logic [LANES-1:0] opa,
    input  logic [LANES-1:0] opb,
    output logic [LANES-1:0] q_true,
    output logic [LANES-1:0] q_comp,
    output logic [LANES-1:0] plain_q
);
    localparam int MASK_W = LANES;

    typedef struct packed {
        phase_e              ph;
        logic [LANES-1:0]    a;
        logic [LANES-1:0]    b;
        logic [MASK_W-1:0]   mask;
        logic [LANES-1:0]    qt;
        logic [LANES-1:0]    qf;
        logic [LANES-1:0]    plain;
    } state_t;

    state_t st_d, st_q;

    logic              eval_ph;
    logic              start_op;
    logic [SR_LEN-1:0] sr_state;
    logic [SR_LEN-1:0] sr_next;

    logic [LANES-1:0] rail_at, rail_af, rail_bt, rail_bf, rail_mt, rail_mf;
    logic [LANES-1:0] lane_qt, lane_qf;

    assign eval_ph  = (st_q.ph == PH_EVAL);
    assign start_op = (st_q.ph == PH_PRE) && evaluate;

    mask_sr #(
        .LEN  (SR_LEN),
        .TAP  (SR_TAP),
        .SEED (SEED)
    ) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (start_op),
        .state_q  (sr_state),
        .state_nx (sr_next)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rail_and_lane u_lane (
            .eval_on (eval_ph),
            .a       (st_q.a[i]),
            .b       (st_q.b[i]),
            .m       (st_q.mask[i]),
            .a_t     (rail_at[i]),
            .a_f     (rail_af[i]),
            .b_t     (rail_bt[i]),
            .b_f     (rail_bf[i]),
            .m_t     (rail_mt[i]),
            .m_f     (rail_mf[i]),
            .q_t     (lane_qt[i]),
            .q_f     (lane_qf[i])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.ph = evaluate ? PH_EVAL : PH_PRE;
        if (start_op) begin
            st_d.a    = opa;
            st_d.b    = opb;
            st_d.mask = sr_next[MASK_W-1:0];
        end
        st_d.qt = lane_qt;
        st_d.qf = lane_qf;
        if (eval_ph) begin
            st_d.plain = lane_qt ^ st_q.mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_true  = st_q.qt;
    assign q_comp  = st_q.qf;
    assign plain_q = st_q.plain;
endmodule

// File: rtl/rail_and_chk.sv
module rail_and_chk #(
    parameter int LANES  = 32,
    parameter int SR_LEN = 89
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ph,
    input logic [LANES-1:0]  a,
    input logic [LANES-1:0]  b,
    input logic [LANES-1:0]  mask,
    input logic [SR_LEN-1:0] sr,
    input logic [LANES-1:0]  at,
    input logic [LANES-1:0]  af,
    input logic [LANES-1:0]  bt,
    input logic [LANES-1:0]  bf,
    input logic [LANES-1:0]  mt,
    input logic [LANES-1:0]  mf,
    input logic [LANES-1:0]  qt_int,
    input logic [LANES-1:0]  qf_int,
    input logic [LANES-1:0]  q_true,
    input logic [LANES-1:0]  q_comp,
    input logic [LANES-1:0]  plain_q
);
    assert_never_both_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((at & af) | (bt & bf) | (mt & mf) | (qt_int & qf_int) | (q_true & q_comp)) == '0);

    assert_eval_complementary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ph |-> (&(at ^ af)) && (&(bt ^ bf)) && (&(mt ^ mf)) && (&(qt_int ^ qf_int)));

    assert_precharge_rails_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ph |-> ((at | af | bt | bf | mt | mf | qt_int | qf_int) == '0));

    assert_out_precharge_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ph) |-> (q_true == '0) && (q_comp == '0));

    assert_out_masked_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ph) |-> (q_true == $past((a & b) ^ mask)) && (q_comp == ~q_true));

    assert_plain_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ph) |-> plain_q == $past(a & b));

    assert_plain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ph) |-> $stable(plain_q));

    assert_capture_only_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ph) |-> $stable(a) && $stable(b) && $stable(mask));

    assert_sr_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr != '0);
endmodule

bind masked_rail_and rail_and_chk #(
    .LANES  (LANES),
    .SR_LEN (SR_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (eval_ph),
    .a       (st_q.a),
    .b       (st_q.b),
    .mask    (st_q.mask),
    .sr      (sr_state),
    .at      (rail_at),
    .af      (rail_af),
    .bt      (rail_bt),
    .bf      (rail_bf),
    .mt      (rail_mt),
    .mf      (rail_mf),
    .qt_int  (lane_qt),
    .qf_int  (lane_qf),
    .q_true  (q_true),
    .q_comp  (q_comp),
    .plain_q (plain_q)
);

// File: tb/masked_rail_and_tb.sv
module masked_rail_and_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          LANES      = 32;
    localparam logic [88:0] SEED       = 89'h1_2345_6789_ABCD_EF01_2345;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evaluate = 1'b0;
    logic [LANES-1:0] opa = '0;
    logic [LANES-1:0] opb = '0;
    logic [LANES-1:0] q_true, q_comp, plain_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [88:0] sr_model = SEED;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_rail_and u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .evaluate (evaluate),
        .opa      (opa),
        .opb      (opb),
        .q_true   (q_true),
        .q_comp   (q_comp),
        .plain_q  (plain_q)
    );

    task automatic check(input string req, input logic [LANES-1:0] act,
                         input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [LANES-1:0] a, input logic [LANES-1:0] b);
        logic [LANES-1:0] m, exp_q;
        sr_model = {sr_model[87:0], sr_model[88] ^ sr_model[37]};
        m        = sr_model[LANES-1:0];
        exp_q    = (a & b) ^ m;
        @(negedge clk);
        evaluate = 1'b1; opa = a; opb = b;
        @(negedge clk);
        opa = ~a; opb = $urandom();
        @(negedge clk);
        check("R3 true rail", q_true, exp_q);
        check("R3 complement rail", q_comp, ~exp_q);
        check("R4 plain result", plain_q, a & b);
        check("R6 mask word", q_true ^ (a & b), m);
        check("R7 no both-high pair", q_true & q_comp, '0);
        evaluate = 1'b0; opa = $urandom(); opb = $urandom();
        @(negedge clk);
        check("R5 operand change ignored", q_true, exp_q);
        @(negedge clk);
        check("R2 precharge true rail", q_true, '0);
        check("R2 precharge complement rail", q_comp, '0);
        check("R4 plain held in precharge", plain_q, a & b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset q_true", q_true, '0);
        check("R1 reset q_comp", q_comp, '0);
        check("R1 reset plain_q", plain_q, '0);
        rst_n = 1'b1;
        @(negedge clk);
        do_op('0, '0);
        do_op('1, '0);
        do_op('0, '1);
        do_op('1, '1);
        do_op(32'hAAAA_AAAA, 32'h5555_5555);
        do_op(32'hF0F0_F0F0, 32'hFF00_FF00);
        for (int k = 0; k < 400; k++) begin
            do_op($urandom(), $urandom());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule